// File: doc/BRIEF.md
# Sample/Hold Trigger Delay Generator

This block turns an asynchronous external trigger into a hold command for a sample/hold front end. The hold is asserted either at once or after a delay that depends on the amplifier gain. The trigger passes through a two-flop synchroniser and a rising-edge detector. It is accepted only when the active-low enable input is low and the active-low inhibit input is high. An accepted trigger fires a one-shot that drives a stretched external-hold pulse of `STRETCH_CYC` clocks. For `LOCK_CYC` clocks after acceptance, further triggers are ignored.

The stretched pulse opens a clock gate for a binary timing counter. A sequencer drives `int_hold`, which keeps the gate open after the pulse ends. When the gate closes, the counter clears synchronously. A two-bit delay select picks the hold source. One code is an immediate path that follows the stretched pulse. The other three codes each pick one counter tap, and the taps are two bits apart, so each delay is four times the next. The hold output is registered and stays high until the gate closes.

The one-shot state machine has three states:
- `OS_IDLE` goes to `OS_STRETCH` when a trigger is accepted.
- `OS_STRETCH` goes to `OS_LOCKOUT` when the width count ends or the inhibit input goes low.
- `OS_LOCKOUT` goes to `OS_IDLE` when the lock-out count ends.

The hold state machine has three states:
- `HS_IDLE` goes to `HS_HOLD` when the gate is open and the source is high.
- `HS_IDLE` goes to `HS_ARMED` when the gate is open and the source is low.
- `HS_ARMED` goes to `HS_HOLD` when the source goes high.
- `HS_ARMED` and `HS_HOLD` both return to `HS_IDLE` when the gate closes.

Top module: `sh_hold_delay`

## Requirements
- R1: An accepted trigger is a rising edge of `trig_in`, seen after a two-flop synchroniser. It drives `ext_hold_o` high for exactly `STRETCH_CYC` cycles. A trigger level held high fires only once.
- R2: If `inhibit_n` is low, an edge is not accepted. If `inhibit_n` goes low while `ext_hold_o` is high, `ext_hold_o` falls at the next clock edge.
- R3: While `trig_en_n` is high, no trigger is accepted.
- R4: While the gate is closed (`ext_hold_o` and `int_hold` both low), `cnt_o` clears to 0 at the next edge.
- R5: While the gate is open, `cnt_o` advances by one every `TICK_DIV` clocks. With `TICK_DIV`=1 it reads k at k edges after `ext_hold_o` rose.
- R6: With `dly_sel`=2'b11 (track/hold), `hold_o` rises one cycle after `ext_hold_o`.
- R7: Each delayed select code picks one counter tap:
  - `dly_sel`=2'b00 (gain x100) uses bit `TAP_SLOW`, default 11.
  - `dly_sel`=2'b10 (gain x10) uses bit `TAP_MID`, default 9.
  - `dly_sel`=2'b01 (gain x1) uses bit `TAP_FAST`, default 7.
  - With `TICK_DIV`=1, `hold_o` rises 2^tap+1 cycles after `ext_hold_o` rises.
- R8: `hold_o` stays high while the gate is open. It falls one cycle after the gate closes.
- R9: For `LOCK_CYC` cycles after acceptance, any further trigger edge is ignored. After that window, the next edge is accepted.
- R10: In a delayed mode without `int_hold`, the gate closes when the stretched pulse ends. The counter then clears, and `hold_o` never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Asynchronous external trigger |
| trig_en_n | input | 1 | Active-low trigger enable |
| inhibit_n | input | 1 | Active-low trigger inhibit |
| int_hold | input | 1 | Internal hold from sequencer; keeps gate open |
| dly_sel | input | 2 | Hold source select (00 x100, 10 x10, 01 x1, 11 track) |
| ext_hold_o | output | 1 | Stretched external hold pulse |
| cnt_o | output | CNT_W | Timing counter value |
| hold_o | output | 1 | Registered hold command |

## Verification
The track code and all three delayed codes are each driven with `int_hold` raised just after the trigger. The measured delays (1, 129, 513, 2049 cycles) separate the four source selections from one another, and would also catch any swap of the two select lines.

A delayed code run without `int_hold` separates gate retention from the stretched pulse alone. The trigger-path patterns separate the qualification gates, the one-shot width and the edge-versus-level detection:
- trigger with enable high;
- trigger with inhibit low;
- inhibit dropped mid-pulse;
- second edge inside and then outside the lock-out window;
- trigger level held high for a long time.

// File: rtl/sh_pkg.sv
package sh_pkg;
    typedef enum logic [1:0] {
        SEL_X100  = 2'b00,
        SEL_X1    = 2'b01,
        SEL_X10   = 2'b10,
        SEL_TRACK = 2'b11
    } dly_sel_e;

    typedef enum logic [1:0] {
        OS_IDLE    = 2'd0,
        OS_STRETCH = 2'd1,
        OS_LOCKOUT = 2'd2
    } os_state_e;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_ARMED = 2'd1,
        HS_HOLD  = 2'd2
    } hs_state_e;
endpackage

// File: rtl/sh_sync_edge.sv
module sh_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sh_trig_oneshot.sv
module sh_trig_oneshot
    import sh_pkg::*;
#(
    parameter int STRETCH_CYC = 400,
    parameter int LOCK_CYC    = 1300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_rise,
    input  logic trig_en_n,
    input  logic inhibit_n,
    output logic ext_hold
);
    localparam int            TW          = $clog2(LOCK_CYC + 1);
    localparam logic [TW-1:0] STRETCH_END = TW'(STRETCH_CYC - 1);
    localparam logic [TW-1:0] LOCK_END    = TW'(LOCK_CYC - 1);
    localparam logic [TW-1:0] LOCK_SAT    = TW'(LOCK_CYC);

    os_state_e     state_q, state_d;
    logic [TW-1:0] tmr_q;
    logic          accept;

    assign accept = trig_rise & ~trig_en_n & inhibit_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OS_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == OS_IDLE) tmr_q <= '0;
            else                    tmr_q <= tmr_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_IDLE:    if (accept) state_d = OS_STRETCH;
            OS_STRETCH: if (!inhibit_n || tmr_q == STRETCH_END) state_d = OS_LOCKOUT;
            OS_LOCKOUT: if (tmr_q == LOCK_END) state_d = OS_IDLE;
            default:    state_d = OS_IDLE;
        endcase
    end

    always_comb begin
        ext_hold = (state_q == OS_STRETCH);
    end

    // Checker state: pulse width and spacing between accepted triggers
    logic          ext_q;
    logic [TW-1:0] gap_q;
    logic [TW-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
            gap_q <= LOCK_SAT;
            hi_q  <= '0;
        end else begin
            ext_q <= ext_hold;
            if (ext_hold && !ext_q)  gap_q <= '0;
            else if (gap_q != LOCK_SAT) gap_q <= gap_q + 1'b1;
            hi_q <= ext_hold ? hi_q + 1'b1 : '0;
        end
    end

    a_r1_width_limit: assert property (@(posedge clk) disable iff (!rst_n)
        ext_hold |-> (hi_q < TW'(STRETCH_CYC)));
    a_r2_inhibit_cuts: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_hold && !inhibit_n) |=> !ext_hold);
    a_r3_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_hold) |-> $past(!trig_en_n && inhibit_n));
    a_r9_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_hold && !ext_q) |-> (gap_q == LOCK_SAT));
endmodule

// File: rtl/sh_gate_counter.sv
module sh_gate_counter #(
    parameter int CNT_W    = 14,
    parameter int TICK_DIV = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_open,
    output logic [CNT_W-1:0] cnt
);
    logic tick;

    generate
        if (TICK_DIV <= 1) begin : g_direct
            assign tick = gate_open;
        end else begin : g_prescale
            localparam int            PW      = $clog2(TICK_DIV);
            localparam logic [PW-1:0] PRE_END = PW'(TICK_DIV - 1);
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (!rst_n || !gate_open) pre_q <= '0;
                else if (pre_q == PRE_END) pre_q <= '0;
                else                        pre_q <= pre_q + 1'b1;
            end
            assign tick = gate_open && (pre_q == PRE_END);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (!gate_open) cnt <= '0;
        else if (tick)       cnt <= cnt + 1'b1;
    end

    a_r4_clear_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open |=> (cnt == '0));
    a_r5_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open && tick) |=> (cnt == $past(cnt) + 1'b1));
    a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open && !tick) |=> $stable(cnt));
endmodule

// File: rtl/sh_hold_select.sv
module sh_hold_select
    import sh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gate_open,
    input  logic       ext_hold,
    input  logic [2:0] taps,
    input  logic [1:0] dly_sel,
    output logic       hold
);
    hs_state_e state_q, state_d;
    logic      src;

    always_comb begin
        src = 1'b0;
        unique case (dly_sel_e'(dly_sel))
            SEL_TRACK: src = ext_hold;
            SEL_X100:  src = taps[2];
            SEL_X10:   src = taps[1];
            SEL_X1:    src = taps[0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE:  if (gate_open) state_d = src ? HS_HOLD : HS_ARMED;
            HS_ARMED: if (!gate_open) state_d = HS_IDLE;
                      else if (src)   state_d = HS_HOLD;
            HS_HOLD:  if (!gate_open) state_d = HS_IDLE;
            default:  state_d = HS_IDLE;
        endcase
    end

    always_comb begin
        hold = (state_q == HS_HOLD);
    end

    a_r6_track_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open && ext_hold && dly_sel == 2'b11) |=> hold);
    a_r7_tap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open && dly_sel != 2'b11 && src) |=> hold);
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !gate_open) |=> !hold);
    a_r8_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> $past(gate_open));
endmodule

// File: rtl/sh_hold_delay.sv
module sh_hold_delay #(
    parameter int CNT_W       = 14,
    parameter int TICK_DIV    = 10,
    parameter int STRETCH_CYC = 400,
    parameter int LOCK_CYC    = 1300,
    parameter int TAP_SLOW    = 11,
    parameter int TAP_MID     = 9,
    parameter int TAP_FAST    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic             trig_en_n,
    input  logic             inhibit_n,
    input  logic             int_hold,
    input  logic [1:0]       dly_sel,
    output logic             ext_hold_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hold_o
);
    logic       trig_rise;
    logic       ext_hold;
    logic       gate_open;
    logic [2:0] taps;

    sh_sync_edge #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(trig_in), .rise(trig_rise)
    );

    sh_trig_oneshot #(.STRETCH_CYC(STRETCH_CYC), .LOCK_CYC(LOCK_CYC)) u_oneshot (
        .clk(clk), .rst_n(rst_n), .trig_rise(trig_rise),
        .trig_en_n(trig_en_n), .inhibit_n(inhibit_n), .ext_hold(ext_hold)
    );

    assign gate_open = ext_hold | int_hold;

    sh_gate_counter #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_counter (
        .clk(clk), .rst_n(rst_n), .gate_open(gate_open), .cnt(cnt_o)
    );

    assign taps = {cnt_o[TAP_SLOW], cnt_o[TAP_MID], cnt_o[TAP_FAST]};

    sh_hold_select u_hold (
        .clk(clk), .rst_n(rst_n), .gate_open(gate_open), .ext_hold(ext_hold),
        .taps(taps), .dly_sel(dly_sel), .hold(hold_o)
    );

    assign ext_hold_o = ext_hold;
endmodule

// File: tb/sh_hold_delay_tb.sv
`timescale 1ns/1ps
module sh_hold_delay_tb;
    localparam int CNT_W = 14;
    localparam int STR   = 40;
    localparam int LOCK  = 130;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig_in = 1'b0;
    logic             trig_en_n = 1'b0;
    logic             inhibit_n = 1'b1;
    logic             int_hold = 1'b0;
    logic [1:0]       dly_sel = 2'b11;
    logic             ext_hold_o;
    logic [CNT_W-1:0] cnt_o;
    logic             hold_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int t_ext_r, t_ext_f, t_hold_r, t_hold_f, n_ext_r;
    logic ext_p = 1'b0, hold_p = 1'b0;

    sh_hold_delay #(.CNT_W(CNT_W), .TICK_DIV(1), .STRETCH_CYC(STR), .LOCK_CYC(LOCK),
                    .TAP_SLOW(11), .TAP_MID(9), .TAP_FAST(7)) u_dut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_en_n(trig_en_n),
        .inhibit_n(inhibit_n), .int_hold(int_hold), .dly_sel(dly_sel),
        .ext_hold_o(ext_hold_o), .cnt_o(cnt_o), .hold_o(hold_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (ext_hold_o && !ext_p) begin t_ext_r = cyc; n_ext_r = n_ext_r + 1; end
        if (!ext_hold_o && ext_p) t_ext_f = cyc;
        if (hold_o && !hold_p) t_hold_r = cyc;
        if (!hold_o && hold_p) t_hold_f = cyc;
        ext_p = ext_hold_o;
        hold_p = hold_o;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic clear_marks();
        t_ext_r = -1; t_ext_f = -1; t_hold_r = -1; t_hold_f = -1; n_ext_r = 0;
    endtask

    task automatic fire();
        step(); trig_in = 1'b1;
        repeat (4) step();
        trig_in = 1'b0;
    endtask

    task automatic settle();
        repeat (LOCK + 20) step();
    endtask

    task automatic t_reset();
        check("R4 reset cnt", int'(cnt_o), 0);
        check("R1 reset ext", int'(ext_hold_o), 0);
        check("R8 reset hold", int'(hold_o), 0);
    endtask

    task automatic t_track();
        clear_marks(); dly_sel = 2'b11; int_hold = 1'b0;
        fire();
        repeat (60) step();
        check("R1 width", t_ext_f - t_ext_r, STR);
        check("R6 track delay", t_hold_r - t_ext_r, 1);
        check("R8 track release", t_hold_f - t_ext_f, 1);
        settle();
    endtask

    task automatic t_delayed(input logic [1:0] sel, input int tap, input string tag);
        int t_drop;
        clear_marks(); dly_sel = sel; int_hold = 1'b0;
        fire();
        int_hold = 1'b1;
        while (t_ext_r < 0) step();
        if (sel == 2'b01) begin
            while (cyc < t_ext_r + 5) step();
            check("R5 count step", int'(cnt_o), 5);
        end
        for (int i = 0; i < 2200 && !hold_o; i++) step();
        check(tag, t_hold_r - t_ext_r, (1 << tap) + 1);
        repeat (20) step();
        check("R8 hold kept", int'(hold_o), 1);
        t_drop = cyc; int_hold = 1'b0;
        step();
        check("R8 hold release", t_hold_f - t_drop, 1);
        check("R4 cleared", int'(cnt_o), 0);
        settle();
    endtask

    task automatic t_no_int();
        clear_marks(); dly_sel = 2'b01; int_hold = 1'b0;
        fire();
        repeat (300) step();
        check("R10 no hold", t_hold_r, -1);
        check("R10 cnt cleared", int'(cnt_o), 0);
        settle();
    endtask

    task automatic t_enable_off();
        clear_marks(); trig_en_n = 1'b1;
        fire(); repeat (20) step();
        check("R3 disabled", n_ext_r, 0);
        trig_en_n = 1'b0;
        settle();
    endtask

    task automatic t_inhibit_on();
        clear_marks(); inhibit_n = 1'b0;
        fire(); repeat (20) step();
        check("R2 inhibited", n_ext_r, 0);
        inhibit_n = 1'b1;
        settle();
    endtask

    task automatic t_inhibit_mid();
        int t_i;
        clear_marks(); dly_sel = 2'b11;
        fire();
        while (t_ext_r < 0) step();
        repeat (9) step();
        t_i = cyc; inhibit_n = 1'b0;
        repeat (3) step();
        check("R2 cut short", t_ext_f - t_i, 1);
        settle();
        inhibit_n = 1'b1;
        settle();
    endtask

    task automatic t_lockout();
        int t0;
        clear_marks(); dly_sel = 2'b11;
        fire();
        while (t_ext_r < 0) step();
        t0 = t_ext_r;
        while (cyc < t0 + 60) step();
        fire(); repeat (20) step();
        check("R9 ignored in lockout", n_ext_r, 1);
        while (cyc < t0 + 200) step();
        fire(); repeat (20) step();
        check("R9 accepted after", n_ext_r, 2);
        settle();
    endtask

    task automatic t_level();
        clear_marks(); dly_sel = 2'b11;
        step(); trig_in = 1'b1;
        repeat (400) step();
        check("R1 level fires once", n_ext_r, 1);
        trig_in = 1'b0;
        settle();
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        clear_marks();
        repeat (4) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_track();
        t_delayed(2'b01, 7,  "R7 x1 delay");
        t_delayed(2'b10, 9,  "R7 x10 delay");
        t_delayed(2'b00, 11, "R7 x100 delay");
        t_no_int();
        t_enable_off();
        t_inhibit_on();
        t_inhibit_mid();
        t_lockout();
        t_level();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule